// File: doc/BRIEF.md
# Offset Register Loader for Almost-Empty / Almost-Full Thresholds

This block keeps the two threshold values that a dual-clock FIFO compares against its fill level to raise its almost-empty and almost-full flags. Each threshold is split into a low byte and a high part. The high part is only as wide as the address bits above bit 7 that the configured depth needs. Software or a controller loads the four pieces one after another from the data input, on the write clock, while the active-low load input is held low. It reads them back in the same order on the read clock.

No address bus selects the pieces. Each clock domain keeps its own 2-bit rotating pointer. The pointer moves on every qualified edge and holds its position while loading or reading is paused, so a load that stops part way resumes at the next piece. The mode is picked at reset release. If the load input is low on the first write and read clock edges after reset, load mode is on. If it is high, the pin is a plain second write enable for the FIFO, and the offsets stay at their reset value of 7.

Top module: `ofs_loader`

## Requirements
- R1: After reset, both assembled offsets equal 7 and the read-back output is all zeros.
- R2: In load mode, each write clock edge with ld_ni and wen1_ni both low writes the next register. The order is 0 empty-low (din bits 7:0), 1 empty-high (din bits HI_W-1:0), 2 full-low and 3 full-high. After register 3 the pointer wraps to register 0.
- R3: When ld_ni goes high, the write and read pointers keep their positions. The next qualified operation continues with the following register.
- R4: A write clock edge with ld_ni high or wen1_ni high leaves all four offset registers unchanged.
- R5: In load mode, each read clock edge with ld_ni, ren1_ni and ren2_ni all low loads rd_data_o with the next register. The order is the same as in R2, and the pointer wraps after register 3.
- R6: When any of ld_ni, ren1_ni or ren2_ni is high, rd_data_o keeps its value across the read clock edge.
- R7: An assembled offset is {high, low}, with HI_W = AW-8 bits in the high part. Bits above the stored width read back as zero.
- R8: If ld_ni is high on the first clock edge after reset release, later load and read attempts change neither the offsets nor rd_data_o.
- R9: A reset returns both pointers to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ni | input | 1 | Load select, active low; its level at reset release picks the mode |
| wen1_ni | input | 1 | Write enable, active low |
| ren1_ni | input | 1 | Read enable 1, active low |
| ren2_ni | input | 1 | Read enable 2, active low |
| din_i | input | DW | Data input |
| rd_data_o | output | DW | Read-back register |
| empty_off_o | output | AW | Assembled almost-empty offset |
| full_off_o | output | AW | Assembled almost-full offset |

## Verification
The assertions assume that ld_ni is stable across reset release, so that both clock domains capture the same mode. They also assume that offset writes and offset reads never overlap in time, because the read side samples the write-side registers without synchronisation. The stimulus respects both assumptions. It changes ld_ni only while reset is held, or after both capture edges have passed. Every write phase finishes before the following read phase starts, and inputs are driven one nanosecond after the clock edge of their own domain.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;

  localparam logic [7:0] OFS_DEFAULT = 8'd7;
endpackage

// File: rtl/ofs_ptr.sv
module ofs_ptr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  output logic [1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= 2'd0;
    else if (adv_i) ptr_o <= ptr_o + 2'd1;
  end

  a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == $past(ptr_o) + 2'd1);
  a_r3_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
  import ofs_pkg::*;
#(
  parameter int DW   = 9,
  parameter int HI_W = 2
) (
  input  logic            wclk_i,
  input  logic            rst_ni,
  input  logic            ld_ni,
  input  logic            wen1_ni,
  input  logic [DW-1:0]   din_i,
  output logic [7:0]      e_lo_o,
  output logic [HI_W-1:0] e_hi_o,
  output logic [7:0]      f_lo_o,
  output logic [HI_W-1:0] f_hi_o
);
  logic       mode_q, locked_q, wr_en;
  logic [1:0] ptr;

  // mode is sampled on the first edge after reset release
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      mode_q   <= ~ld_ni;
      locked_q <= 1'b1;
    end
  end

  assign wr_en = locked_q && mode_q && !ld_ni && !wen1_ni;

  ofs_ptr u_ptr (.clk_i(wclk_i), .rst_ni(rst_ni), .adv_i(wr_en), .ptr_o(ptr));

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_lo_o <= OFS_DEFAULT;
      f_lo_o <= OFS_DEFAULT;
      e_hi_o <= '0;
      f_hi_o <= '0;
    end else if (wr_en) begin
      unique case (ofs_sel_e'(ptr))
        SEL_E_LO: e_lo_o <= din_i[7:0];
        SEL_E_HI: e_hi_o <= din_i[HI_W-1:0];
        SEL_F_LO: f_lo_o <= din_i[7:0];
        SEL_F_HI: f_hi_o <= din_i[HI_W-1:0];
      endcase
    end
  end

  a_r4_no_write_hold: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (ld_ni || wen1_ni) |=> $stable(e_lo_o) && $stable(e_hi_o) && $stable(f_lo_o) && $stable(f_hi_o));
  a_r8_mode_blocks: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (locked_q && !mode_q) |=> $stable(e_lo_o) && $stable(f_lo_o) && $stable(e_hi_o) && $stable(f_hi_o));
  a_r2_lo_capture: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en && ptr == 2'd0) |=> e_lo_o == $past(din_i[7:0]));
endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side
  import ofs_pkg::*;
#(
  parameter int DW   = 9,
  parameter int HI_W = 2
) (
  input  logic            rclk_i,
  input  logic            rst_ni,
  input  logic            ld_ni,
  input  logic            ren1_ni,
  input  logic            ren2_ni,
  input  logic [7:0]      e_lo_i,
  input  logic [HI_W-1:0] e_hi_i,
  input  logic [7:0]      f_lo_i,
  input  logic [HI_W-1:0] f_hi_i,
  output logic [DW-1:0]   rd_data_o
);
  logic          mode_q, locked_q, rd_en;
  logic [1:0]    ptr;
  logic [DW-1:0] sel_val;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      mode_q   <= ~ld_ni;
      locked_q <= 1'b1;
    end
  end

  assign rd_en = locked_q && mode_q && !ld_ni && !ren1_ni && !ren2_ni;

  ofs_ptr u_ptr (.clk_i(rclk_i), .rst_ni(rst_ni), .adv_i(rd_en), .ptr_o(ptr));

  // offsets are quasi-static: read only while no write is in progress
  always_comb begin
    unique case (ofs_sel_e'(ptr))
      SEL_E_LO: sel_val = {{(DW-8){1'b0}}, e_lo_i};
      SEL_E_HI: sel_val = {{(DW-HI_W){1'b0}}, e_hi_i};
      SEL_F_LO: sel_val = {{(DW-8){1'b0}}, f_lo_i};
      default:  sel_val = {{(DW-HI_W){1'b0}}, f_hi_i};
    endcase
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_data_o <= '0;
    else if (rd_en) rd_data_o <= sel_val;
  end

  a_r6_out_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ld_ni || ren1_ni || ren2_ni) |=> $stable(rd_data_o));
  a_r5_full_lo_read: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en && ptr == 2'd2) |=> rd_data_o[7:0] == $past(f_lo_i));
  a_r7_upper_zero: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en && ptr[0]) |=> rd_data_o[DW-1:HI_W] == '0);
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader #(
  parameter int DW    = 9,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int HI_W = (AW > 8) ? (AW - 8) : 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ld_ni,
  input  logic          wen1_ni,
  input  logic          ren1_ni,
  input  logic          ren2_ni,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] empty_off_o,
  output logic [AW-1:0] full_off_o
);
  logic [7:0]      e_lo, f_lo;
  logic [HI_W-1:0] e_hi, f_hi;

  ofs_wr_side #(.DW(DW), .HI_W(HI_W)) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .ld_ni(ld_ni), .wen1_ni(wen1_ni),
    .din_i(din_i), .e_lo_o(e_lo), .e_hi_o(e_hi), .f_lo_o(f_lo), .f_hi_o(f_hi)
  );

  ofs_rd_side #(.DW(DW), .HI_W(HI_W)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .ld_ni(ld_ni), .ren1_ni(ren1_ni),
    .ren2_ni(ren2_ni), .e_lo_i(e_lo), .e_hi_i(e_hi), .f_lo_i(f_lo),
    .f_hi_i(f_hi), .rd_data_o(rd_data_o)
  );

  generate
    if (AW > 8) begin : g_split
      assign empty_off_o = {e_hi, e_lo};
      assign full_off_o  = {f_hi, f_lo};
    end else begin : g_narrow
      assign empty_off_o = e_lo[AW-1:0];
      assign full_off_o  = f_lo[AW-1:0];
    end
  endgenerate

  a_r1_reset_default: assert property (@(posedge wclk_i)
    $rose(rst_ni) |-> empty_off_o == AW'(7) && full_off_o == AW'(7));
endmodule

// File: tb/sim_ofs_loader.sv
`timescale 1ns/1ps
module sim_ofs_loader;
  localparam int DW = 9, DEPTH = 1024, AW = 10, HI_W = 2;

  logic wclk = 0, rclk = 0, rst_ni = 0;
  logic ld_ni = 0, wen1_ni = 1, ren1_ni = 1, ren2_ni = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] e_off, f_off;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [7:0] m_reg [4];
  int m_wp = 0, m_rp = 0;
  logic [DW-1:0] m_out = '0;

  ofs_loader #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .ld_ni(ld_ni),
    .wen1_ni(wen1_ni), .ren1_ni(ren1_ni), .ren2_ni(ren2_ni), .din_i(din),
    .rd_data_o(rd_data), .empty_off_o(e_off), .full_off_o(f_off)
  );

  always #2.5 wclk = ~wclk;
  initial begin #1.25; forever #2.5 rclk = ~rclk; end

  always @(posedge wclk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_e();
    return {m_reg[1][HI_W-1:0], m_reg[0]};
  endfunction
  function automatic logic [AW-1:0] exp_f();
    return {m_reg[3][HI_W-1:0], m_reg[2]};
  endfunction

  task automatic model_reset();
    m_reg[0] = 8'd7; m_reg[1] = 8'd0; m_reg[2] = 8'd7; m_reg[3] = 8'd0;
    m_wp = 0; m_rp = 0; m_out = '0;
  endtask

  task automatic do_reset(bit load_mode);
    rst_ni = 0; ld_ni = !load_mode; wen1_ni = 1; ren1_ni = 1; ren2_ni = 1;
    model_reset();
    #12;
    @(negedge wclk); rst_ni = 1;
    @(posedge wclk); #1;
    @(posedge rclk); #1;
  endtask

  // write domain cycle, model applies only in load mode
  task automatic wr_cyc(bit lm, bit ld, bit wen, logic [DW-1:0] d);
    ld_ni = ld; wen1_ni = wen; din = d;
    @(posedge wclk); #1;
    if (lm && !ld && !wen) begin
      m_reg[m_wp] = (m_wp[0]) ? {6'd0, d[HI_W-1:0]} : d[7:0];
      m_wp = (m_wp + 1) % 4;
    end
    ld_ni = 1; wen1_ni = 1;
  endtask

  task automatic rd_cyc(bit lm, bit ld, bit r1, bit r2);
    ld_ni = ld; ren1_ni = r1; ren2_ni = r2;
    @(posedge rclk); #1;
    if (lm && !ld && !r1 && !r2) begin
      m_out = {1'b0, m_reg[m_rp]};
      m_rp = (m_rp + 1) % 4;
    end
    ld_ni = 1; ren1_ni = 1; ren2_ni = 1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(1);
    chk("R1 empty_off", e_off, 7);
    chk("R1 full_off", f_off, 7);
    chk("R1 rd_data", rd_data, 0);

    // partial load, pause, resume
    wr_cyc(1, 0, 0, 9'h0A5);
    wr_cyc(1, 0, 0, 9'h1FE);
    chk("R2 empty after two", e_off, exp_e());
    for (int i = 0; i < 3; i++) wr_cyc(1, 1, 0, 9'h133);
    for (int i = 0; i < 3; i++) wr_cyc(1, 0, 1, 9'h144);
    chk("R4 empty held", e_off, exp_e());
    chk("R4 full held", f_off, 7);
    wr_cyc(1, 0, 0, 9'h03C);
    chk("R3 resume hits full-lo", f_off, {2'b00, 8'h3C});
    wr_cyc(1, 0, 0, 9'h1C1);
    chk("R2 full-hi", f_off, {2'b01, 8'h3C});
    chk("R7 empty assembled", e_off, {2'b10, 8'hA5});
    wr_cyc(1, 0, 0, 9'h05A);
    chk("R2 wrap to empty-lo", e_off, {2'b10, 8'h5A});

    // read back with pauses
    for (int i = 0; i < 5; i++) begin
      rd_cyc(1, 0, 0, 0);
      chk("R5 read order", rd_data, m_out);
      rd_cyc(1, 0, 0, 1);
      chk("R6 hold ren2", rd_data, m_out);
      rd_cyc(1, 1, 0, 0);
      chk("R3 hold ld high", rd_data, m_out);
    end

    // random write phase
    for (int i = 0; i < 60; i++) begin
      wr_cyc(1, 1'($urandom % 3 == 0), 1'($urandom % 3 == 0), DW'($urandom));
      chk("R2/R4 rand empty", e_off, exp_e());
      chk("R2/R4 rand full", f_off, exp_f());
    end
    for (int i = 0; i < 12; i++) begin
      rd_cyc(1, 0, 1'($urandom % 2), 1'($urandom % 4 == 0));
      chk("R5/R6 rand read", rd_data, m_out);
      chk("R7 upper zero", rd_data[DW-1:8], 0);
    end

    // two-enable mode: loading and reading blocked
    do_reset(0);
    for (int i = 0; i < 4; i++) wr_cyc(0, 0, 0, 9'h0FF);
    chk("R8 empty stays", e_off, 7);
    chk("R8 full stays", f_off, 7);
    for (int i = 0; i < 3; i++) rd_cyc(0, 0, 0, 0);
    chk("R8 rd_data stays", rd_data, 0);

    // pointer return after reset
    do_reset(1);
    wr_cyc(1, 0, 0, 9'h0FF);
    wr_cyc(1, 0, 0, 9'h011);
    wr_cyc(1, 0, 0, 9'h022);
    do_reset(1);
    wr_cyc(1, 0, 0, 9'h066);
    chk("R9 write ptr at 0", e_off, {2'b00, 8'h66});
    chk("R9 full untouched", f_off, 7);
    rd_cyc(1, 0, 0, 0);
    chk("R9 read ptr at 0", rd_data, 9'h066);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule